// File: doc/BRIEF.md
# Zero-Run Sparse Stream Codec

This block packs and unpacks streams of 32-bit activation words that tend to contain long stretches of zeros. On the encode side, each word either passes through unchanged or is folded into a pair: a data value with a 4-bit count of the zero words that followed it. On the decode side, beats in either form are expanded back into the original word sequence. Each pair travels as one beat: data, count and a coded flag side by side. Because every value carries exactly one count, no separate marker is needed to tell counts from data.

Each map, which is a run of words closed by the last flag, starts in pass-through form. An on-line judge scores the first `WINDOW` words of the map. It adds one point for every nonzero word that lands within a short gap after the previous nonzero word. A high score means the map is dense, and it stays in pass-through form. A low score means the map is sparse, and coding starts with the next word. Both paths use valid/ready handshakes and a last flag, and both hold a single output register.

Top module: `zr_codec`

## Requirements
- R1: After reset, both output valids are low and both input readies are high.
- R2: Each map starts in pass-through form. Each word leaves as one beat with the coded flag at 0, the count at 0, the same data and the same last flag. A map of at most `WINDOW` words never leaves pass-through form.
- R3: In coded form, each beat carries a value and a count. The count is the number of zero words that followed that value in the input before the next emitted value.
- R4: A count never exceeds 15. The zero word after 15 counted zeros is emitted as a literal zero value that carries its own count.
- R5: A zero word that arrives while no value is held (the first coded word of a map) becomes a literal zero value.
- R6: The judge adds one point to a 16-bit saturating score for each nonzero word whose previous nonzero word in the map was fewer than `GAP_LIMIT` (8) zero words earlier.
- R7: When the `WINDOW`-th word of a map is taken and that word is not the last one, a score above `DENSE_LIMIT` keeps pass-through form. Otherwise coding starts with word `WINDOW`+1.
- R8: The last word of a map flushes any held value with its current count, and the final beat of the map carries the last flag. The judge and the form then return to their start state for the next map.
- R9: The decoder turns a beat with coded flag 0 into one word. It turns a beat with coded flag 1 into its value followed by as many zero words as the count says. The last flag appears on the final word of the final beat's expansion.
- R10: While an output is valid and not accepted, all of its fields hold steady. Under backpressure no word is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_in_valid | input | 1 | Encoder input word valid |
| enc_in_ready | output | 1 | Encoder can take a word |
| enc_in_data | input | 32 | Encoder input word |
| enc_in_last | input | 1 | Final word of the map |
| enc_out_valid | output | 1 | Encoder beat valid |
| enc_out_ready | input | 1 | Downstream takes the encoder beat |
| enc_out_data | output | 32 | Value or passed word |
| enc_out_idx | output | 4 | Count of zero words after the value |
| enc_out_coded | output | 1 | 1 = coded pair, 0 = pass-through word |
| enc_out_last | output | 1 | Final beat of the map |
| dec_in_valid | input | 1 | Decoder beat valid |
| dec_in_ready | output | 1 | Decoder can take a beat |
| dec_in_data | input | 32 | Beat value |
| dec_in_idx | input | 4 | Beat count |
| dec_in_coded | input | 1 | Beat form |
| dec_in_last | input | 1 | Final beat of the map |
| dec_out_valid | output | 1 | Restored word valid |
| dec_out_ready | input | 1 | Downstream takes the word |
| dec_out_data | output | 32 | Restored word |
| dec_out_last | output | 1 | Final word of the map |

## Verification
The bench probes the score just below and just above the dense limit. It also places a gap of exactly 7 zeros and one of exactly 8 zeros before a nonzero word. A judge with an off-by-one comparison would pick the wrong form, and the coded flag would show it on the next word. Other maps contain zero runs of exactly 15, 16 and 20 words, zeros right after the switch to coded form, trailing zeros, and a nonzero last word that arrives while a value is held. Each of these fails in a visible way if the design is wrong: a saturated count that wraps to 0, a leading zero that is dropped, a flush that loses a value, or a flush that sets the last flag twice. Every map is passed back through the decoder under stalls and must come out identical to its input. A hold or fill error would therefore show up as a missing, repeated or shifted word.

// File: rtl/zr_pkg.sv
package zr_pkg;

  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  typedef enum logic [0:0] {
    MODE_PLAIN  = 1'b0,
    MODE_ENCODE = 1'b1
  } mode_e;

  function automatic logic run_full(input logic [IDX_W-1:0] cnt);
    return cnt == IDX_MAX;
  endfunction

  function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] cnt);
    return cnt + 1'b1;
  endfunction

  function automatic logic [IDX_W-1:0] idx_drop(input logic [IDX_W-1:0] cnt);
    return cnt - 1'b1;
  endfunction

endpackage

// File: rtl/zr_classifier.sv
module zr_classifier
  import zr_pkg::*;
#(
  parameter int WINDOW      = 65536,
  parameter int DENSE_LIMIT = 32768,
  parameter int GAP_LIMIT   = 8,
  parameter int CNT_W       = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  logic  word_zero,
  input  logic  word_last,
  output mode_e mode
);

  localparam int WC_W  = $clog2(WINDOW + 1);
  localparam int GAP_W = $clog2(GAP_LIMIT + 1);
  localparam logic [WC_W-1:0]  WC_END  = WC_W'(WINDOW - 1);
  localparam logic [GAP_W-1:0] GAP_L   = GAP_W'(GAP_LIMIT);
  localparam logic [CNT_W-1:0] DENSE_L = CNT_W'(DENSE_LIMIT);

  logic [WC_W-1:0]  wcnt_q;
  logic [GAP_W-1:0] gap_q;
  logic [CNT_W-1:0] score_q, score_nx;
  logic             seen_nz_q, decided_q;
  mode_e            mode_q;
  logic             hit, decide_evt;

  assign hit        = accept && !word_zero && seen_nz_q && (gap_q < GAP_L) && !decided_q;
  assign score_nx   = (hit && score_q != '1) ? score_q + 1'b1 : score_q;
  assign decide_evt = accept && !word_last && !decided_q && (wcnt_q == WC_END);
  assign mode       = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt_q    <= '0;
      gap_q     <= '0;
      score_q   <= '0;
      seen_nz_q <= 1'b0;
      decided_q <= 1'b0;
      mode_q    <= MODE_PLAIN;
    end else if (accept) begin
      if (word_last) begin
        wcnt_q    <= '0;
        gap_q     <= '0;
        score_q   <= '0;
        seen_nz_q <= 1'b0;
        decided_q <= 1'b0;
        mode_q    <= MODE_PLAIN;
      end else begin
        score_q <= score_nx;
        if (word_zero) begin
          if (gap_q != GAP_L) gap_q <= gap_q + 1'b1;
        end else begin
          gap_q     <= '0;
          seen_nz_q <= 1'b1;
        end
        if (!decided_q) wcnt_q <= wcnt_q + 1'b1;
        if (decide_evt) begin
          decided_q <= 1'b1;
          mode_q    <= (score_nx > DENSE_L) ? MODE_PLAIN : MODE_ENCODE;
        end
      end
    end
  end

  // R7: coding is entered only through a window decision
  a_r7_enter_on_decide: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q == MODE_ENCODE) |-> $past(decide_evt));

  // R6: the score never falls within a map
  a_r6_score_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !word_last) |=> (score_q >= $past(score_q)));

endmodule

// File: rtl/zr_encoder.sv
module zr_encoder
  import zr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic             in_last,
  output logic             accept_o,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic [IDX_W-1:0] out_idx,
  output logic             out_coded,
  output logic             out_last
);

  logic             ov_q, oc_q, ol_q;
  logic [DW-1:0]    od_q;
  logic [IDX_W-1:0] oi_q;

  logic             pend_v, flush_q;
  logic [DW-1:0]    pend_d;
  logic [IDX_W-1:0] pend_c;

  logic             can_load, accept, word_zero, run_cap_evt;
  logic             emit_v, emit_enc, emit_last;
  logic [DW-1:0]    emit_d;
  logic [IDX_W-1:0] emit_c;
  logic             n_pv, n_fl;
  logic [DW-1:0]    n_pd;
  logic [IDX_W-1:0] n_pc;

  assign can_load  = !ov_q || out_ready;
  assign in_ready  = can_load && !flush_q;
  assign accept    = in_valid && in_ready;
  assign accept_o  = accept;
  assign word_zero = (in_data == '0);

  always_comb begin
    emit_v      = 1'b0;
    emit_d      = pend_d;
    emit_c      = pend_c;
    emit_enc    = 1'b1;
    emit_last   = 1'b0;
    n_pv        = pend_v;
    n_pd        = pend_d;
    n_pc        = pend_c;
    n_fl        = flush_q;
    run_cap_evt = 1'b0;
    if (flush_q && can_load) begin
      emit_v    = 1'b1;
      emit_last = 1'b1;
      n_pv      = 1'b0;
      n_pc      = '0;
      n_fl      = 1'b0;
    end else if (accept) begin
      if (mode == MODE_PLAIN) begin
        emit_v    = 1'b1;
        emit_d    = in_data;
        emit_c    = '0;
        emit_enc  = 1'b0;
        emit_last = in_last;
      end else begin
        if (!pend_v) begin
          n_pv = 1'b1;
          n_pd = in_data;
          n_pc = '0;
        end else if (!word_zero || run_full(pend_c)) begin
          emit_v      = 1'b1;
          run_cap_evt = word_zero;
          n_pd        = in_data;
          n_pc        = '0;
        end else begin
          n_pc = idx_step(pend_c);
        end
        n_fl = in_last;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v  <= 1'b0;
      pend_d  <= '0;
      pend_c  <= '0;
      flush_q <= 1'b0;
    end else begin
      pend_v  <= n_pv;
      pend_d  <= n_pd;
      pend_c  <= n_pc;
      flush_q <= n_fl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      od_q <= '0;
      oi_q <= '0;
      oc_q <= 1'b0;
      ol_q <= 1'b0;
    end else if (can_load) begin
      ov_q <= emit_v;
      if (emit_v) begin
        od_q <= emit_d;
        oi_q <= emit_c;
        oc_q <= emit_enc;
        ol_q <= emit_last;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_idx   = oi_q;
  assign out_coded = oc_q;
  assign out_last  = ol_q;

  // R10: a stalled beat keeps every field
  a_r10_enc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_idx)
                                   && $stable(out_coded) && $stable(out_last)));

  // R4: a run cut by saturation leaves with the full count
  a_r4_cap_count: assert property (@(posedge clk) disable iff (!rst_n)
    run_cap_evt |=> (out_valid && out_coded && out_idx == IDX_MAX));

  // R2: pass-through beats carry no count
  a_r2_plain_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_coded) |-> (out_idx == '0));

endmodule

// File: rtl/zr_decoder.sv
module zr_decoder
  import zr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic [IDX_W-1:0] in_idx,
  input  logic             in_coded,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_last
);

  logic             ov_q, ol_q, last_hold;
  logic [DW-1:0]    od_q;
  logic [IDX_W-1:0] left_q, take_n;
  logic             can_load, accept, fill_evt;

  assign can_load = !ov_q || out_ready;
  assign in_ready = can_load && (left_q == '0);
  assign accept   = in_valid && in_ready;
  assign fill_evt = can_load && (left_q != '0);
  assign take_n   = in_coded ? in_idx : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q      <= 1'b0;
      od_q      <= '0;
      ol_q      <= 1'b0;
      left_q    <= '0;
      last_hold <= 1'b0;
    end else if (can_load) begin
      if (fill_evt) begin
        ov_q   <= 1'b1;
        od_q   <= '0;
        ol_q   <= last_hold && (left_q == IDX_W'(1));
        left_q <= idx_drop(left_q);
      end else if (accept) begin
        ov_q      <= 1'b1;
        od_q      <= in_data;
        ol_q      <= in_last && (take_n == '0);
        left_q    <= take_n;
        last_hold <= in_last;
      end else begin
        ov_q <= 1'b0;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_last  = ol_q;

  // R10: a stalled word keeps its value and flag
  a_r10_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R9: every fill step produces a zero word
  a_r9_fill_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> (out_valid && out_data == '0));

endmodule

// File: rtl/zr_codec.sv
module zr_codec
  import zr_pkg::*;
#(
  parameter int DW          = 32,
  parameter int WINDOW      = 65536,
  parameter int DENSE_LIMIT = 32768,
  parameter int GAP_LIMIT   = 8,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_in_valid,
  output logic             enc_in_ready,
  input  logic [DW-1:0]    enc_in_data,
  input  logic             enc_in_last,
  output logic             enc_out_valid,
  input  logic             enc_out_ready,
  output logic [DW-1:0]    enc_out_data,
  output logic [IDX_W-1:0] enc_out_idx,
  output logic             enc_out_coded,
  output logic             enc_out_last,
  input  logic             dec_in_valid,
  output logic             dec_in_ready,
  input  logic [DW-1:0]    dec_in_data,
  input  logic [IDX_W-1:0] dec_in_idx,
  input  logic             dec_in_coded,
  input  logic             dec_in_last,
  output logic             dec_out_valid,
  input  logic             dec_out_ready,
  output logic [DW-1:0]    dec_out_data,
  output logic             dec_out_last
);

  mode_e cur_mode;
  logic  enc_accept;

  zr_classifier #(
    .WINDOW(WINDOW), .DENSE_LIMIT(DENSE_LIMIT), .GAP_LIMIT(GAP_LIMIT), .CNT_W(CNT_W)
  ) u_judge (
    .clk(clk), .rst_n(rst_n),
    .accept(enc_accept), .word_zero(enc_in_data == '0), .word_last(enc_in_last),
    .mode(cur_mode)
  );

  zr_encoder #(.DW(DW)) u_enc (
    .clk(clk), .rst_n(rst_n), .mode(cur_mode),
    .in_valid(enc_in_valid), .in_ready(enc_in_ready), .in_data(enc_in_data),
    .in_last(enc_in_last), .accept_o(enc_accept),
    .out_valid(enc_out_valid), .out_ready(enc_out_ready), .out_data(enc_out_data),
    .out_idx(enc_out_idx), .out_coded(enc_out_coded), .out_last(enc_out_last)
  );

  zr_decoder #(.DW(DW)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .in_valid(dec_in_valid), .in_ready(dec_in_ready), .in_data(dec_in_data),
    .in_idx(dec_in_idx), .in_coded(dec_in_coded), .in_last(dec_in_last),
    .out_valid(dec_out_valid), .out_ready(dec_out_ready), .out_data(dec_out_data),
    .out_last(dec_out_last)
  );

  // R8: a map end returns the path to pass-through form
  a_r8_mode_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_accept && enc_in_last) |=> (cur_mode == MODE_PLAIN));

endmodule

// File: tb/tb_zr_codec.sv
module tb_zr_codec;
  localparam int WIN = 32;
  localparam int DLIM = 16;
  localparam int GAP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        ei_valid = 0, ei_last = 0, eo_ready = 1;
  logic [31:0] ei_data = 0;
  logic        di_valid = 0, di_last = 0, di_coded = 0, do_ready = 1;
  logic [31:0] di_data = 0;
  logic [3:0]  di_idx = 0;
  logic        ei_ready, eo_valid, eo_coded, eo_last, di_ready, do_valid, do_last;
  logic [31:0] eo_data, do_data;
  logic [3:0]  eo_idx;

  zr_codec #(.WINDOW(WIN), .DENSE_LIMIT(DLIM), .GAP_LIMIT(GAP)) dut (
    .clk(clk), .rst_n(rst_n),
    .enc_in_valid(ei_valid), .enc_in_ready(ei_ready), .enc_in_data(ei_data), .enc_in_last(ei_last),
    .enc_out_valid(eo_valid), .enc_out_ready(eo_ready), .enc_out_data(eo_data),
    .enc_out_idx(eo_idx), .enc_out_coded(eo_coded), .enc_out_last(eo_last),
    .dec_in_valid(di_valid), .dec_in_ready(di_ready), .dec_in_data(di_data),
    .dec_in_idx(di_idx), .dec_in_coded(di_coded), .dec_in_last(di_last),
    .dec_out_valid(do_valid), .dec_out_ready(do_ready), .dec_out_data(do_data),
    .dec_out_last(do_last)
  );

  int errs = 0, checks = 0;
  logic [31:0] win [0:255];
  int n_in;
  logic [31:0] cb_d [0:255]; logic [3:0] cb_i [0:255]; logic cb_c [0:255]; logic cb_l [0:255];
  int n_cb;
  logic [31:0] xb_d [0:255]; logic [3:0] xb_i [0:255]; logic xb_c [0:255]; logic xb_l [0:255];
  int n_xb;
  logic [31:0] dw [0:255]; logic dl [0:255];
  int n_dw;
  int hold_bad;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] v, input int cnt);
    for (int k = 0; k < cnt; k++) begin win[n_in] = v; n_in++; end
  endtask

  task automatic put_nz(input int cnt);
    for (int k = 0; k < cnt; k++) begin win[n_in] = 32'h4000_0000 + 32'(n_in); n_in++; end
  endtask

  // nonzero word j scores when another nonzero word sits at most GAP places back
  function automatic int window_score();
    int s = 0;
    for (int j = 0; j < WIN; j++) begin
      if (win[j] != 0) begin
        for (int k = j - 1; k >= 0 && k >= j - GAP; k--)
          if (win[k] != 0) begin s++; break; end
      end
    end
    return s;
  endfunction

  task automatic add_x(input logic [31:0] d, input int z, input bit c, input bit l);
    xb_d[n_xb] = d; xb_i[n_xb] = 4'(z); xb_c[n_xb] = c; xb_l[n_xb] = l; n_xb++;
  endtask

  task automatic build_expected();
    int start, i, z;
    n_xb = 0;
    start = n_in;
    if (n_in > WIN && window_score() <= DLIM) start = WIN;
    for (int p = 0; p < start; p++) add_x(win[p], 0, 1'b0, p == n_in - 1);
    i = start;
    while (i < n_in) begin
      logic [31:0] v;
      v = win[i]; i++; z = 0;
      while (i < n_in && win[i] == 0 && z < 15) begin z++; i++; end
      add_x(v, z, 1'b1, i >= n_in);
    end
  endtask

  task automatic enc_drive();
    for (int i = 0; i < n_in; i++) begin
      @(negedge clk);
      ei_valid = 1; ei_data = win[i]; ei_last = (i == n_in - 1);
      #1;
      while (!ei_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    ei_valid = 0; ei_last = 0;
  endtask

  task automatic enc_collect(input bit stall);
    bit done = 0, held = 0;
    logic [35:0] hv = 0;
    int cyc = 0;
    n_cb = 0;
    while (!done) begin
      @(negedge clk);
      eo_ready = stall ? (cyc % 3 != 1) : 1'b1;
      cyc++;
      #1;
      if (held && eo_valid && {eo_data, eo_idx} != hv) hold_bad++;
      held = eo_valid && !eo_ready;
      hv = {eo_data, eo_idx};
      if (eo_valid && eo_ready && n_cb < 256) begin
        cb_d[n_cb] = eo_data; cb_i[n_cb] = eo_idx; cb_c[n_cb] = eo_coded; cb_l[n_cb] = eo_last;
        n_cb++;
        if (eo_last) done = 1;
      end
    end
    @(negedge clk); eo_ready = 1;
  endtask

  task automatic dec_drive();
    for (int i = 0; i < n_cb; i++) begin
      @(negedge clk);
      di_valid = 1; di_data = cb_d[i]; di_idx = cb_i[i]; di_coded = cb_c[i]; di_last = cb_l[i];
      #1;
      while (!di_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    di_valid = 0; di_last = 0;
  endtask

  task automatic dec_collect(input bit stall);
    bit done = 0, held = 0;
    logic [31:0] hv = 0;
    int cyc = 0;
    n_dw = 0;
    while (!done) begin
      @(negedge clk);
      do_ready = stall ? (cyc % 4 != 2) : 1'b1;
      cyc++;
      #1;
      if (held && do_valid && do_data != hv) hold_bad++;
      held = do_valid && !do_ready;
      hv = do_data;
      if (do_valid && do_ready && n_dw < 256) begin
        dw[n_dw] = do_data; dl[n_dw] = do_last; n_dw++;
        if (do_last) done = 1;
      end
    end
    @(negedge clk); do_ready = 1;
  endtask

  task automatic run_map(input string tag, input string req, input bit stall);
    int bad = 0;
    hold_bad = 0;
    build_expected();
    fork enc_drive(); enc_collect(stall); join
    chk(n_cb == n_xb, req, {tag, " beat count"}, 32'(n_cb), 32'(n_xb));
    for (int i = 0; i < n_xb && i < n_cb; i++) begin
      if (cb_d[i] != xb_d[i] || cb_c[i] != xb_c[i] || cb_l[i] != xb_l[i] ||
          (xb_c[i] && cb_i[i] != xb_i[i]) || (!xb_c[i] && cb_i[i] != 0)) begin
        bad++;
        $display("FAIL %s %s beat %0d: actual=%h/%0d/%0b/%0b expected=%h/%0d/%0b/%0b", req, tag, i,
                 cb_d[i], cb_i[i], cb_c[i], cb_l[i], xb_d[i], xb_i[i], xb_c[i], xb_l[i]);
      end
    end
    checks++; if (bad != 0) errs++;
    // R9: decoder restores the original map
    fork dec_drive(); dec_collect(stall); join
    chk(n_dw == n_in, "R9", {tag, " restored length"}, 32'(n_dw), 32'(n_in));
    bad = 0;
    for (int i = 0; i < n_in && i < n_dw; i++)
      if (dw[i] != win[i] || dl[i] != (i == n_in - 1)) begin
        bad++;
        $display("FAIL R9 %s word %0d: actual=%h/%0b expected=%h/%0b", tag, i, dw[i], dl[i],
                 win[i], i == n_in - 1);
      end
    checks++; if (bad != 0) errs++;
    if (stall) chk(hold_bad == 0, "R10", {tag, " held outputs stable"}, 32'(hold_bad), 0);
  endtask

  task automatic t_reset();
    chk(eo_valid == 0 && do_valid == 0, "R1", "output valids after reset", {30'b0, eo_valid, do_valid}, 0);
    chk(ei_ready == 1 && di_ready == 1, "R1", "input readies after reset", {30'b0, ei_ready, di_ready}, 3);
  endtask

  task automatic t_short_plain();
    n_in = 0;
    put(32'h5, 1); put(0, 2); put(32'h7, 1); put(0, 1); put(32'h9, 1);
    run_map("short map", "R2", 0);
  endtask

  task automatic t_sparse_runs();
    n_in = 0;
    put(0, WIN);
    put(0, 3); put(32'hA, 1); put(0, 3); put(32'hB, 1);   // R5 leading zeros, R3 counts
    put(0, 20); put(32'hC, 1); put(0, 15);                // R4 run cut at 15
    put(32'hD, 1); put(32'hE, 1);                          // R8 nonzero last word behind a held value
    run_map("sparse runs", "R3 R4 R5 R8", 0);
  endtask

  task automatic t_trailing_zeros();
    n_in = 0;
    put(0, WIN); put(32'h77, 1); put(0, 16);               // R4 and R8: 16th zero is the last word
    run_map("trailing zeros", "R4 R8", 0);
  endtask

  task automatic t_dense();
    n_in = 0;
    put_nz(WIN); put(0, 2); put(32'h5, 1);
    run_map("dense map", "R7", 0);
    chk(cb_c[0] == 0, "R8", "next map restarts in pass-through form", 32'(cb_c[0]), 0);
  endtask

  task automatic t_boundary();
    n_in = 0;
    put_nz(17); put(0, 8); put_nz(1); put(0, WIN - 26);   // score 16, gap of 8 does not score
    put(32'h5, 1); put(0, 1); put(32'h6, 1);
    run_map("score at limit", "R6 R7", 0);
    chk(n_cb > WIN && cb_c[WIN] == 1, "R7", "coding after score at limit", 32'(cb_c[WIN]), 1);
    n_in = 0;
    put_nz(17); put(0, 7); put_nz(1); put(0, WIN - 25);   // score 17, gap of 7 scores
    put(32'h5, 1); put(0, 1); put(32'h6, 1);
    run_map("score over limit", "R6 R7", 0);
    chk(n_cb > WIN && cb_c[WIN] == 0, "R7", "pass-through after score over limit", 32'(cb_c[WIN]), 0);
  endtask

  task automatic t_backpressure();
    n_in = 0;
    put(0, WIN); put(32'h1, 1); put(0, 17); put(32'h2, 1); put(32'h3, 1); put(0, 4);
    run_map("stalled sparse map", "R10", 1);
    n_in = 0;
    put_nz(10); put(0, 3); put(32'h8, 1);
    run_map("stalled plain map", "R10", 1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_short_plain();
    t_sparse_runs();
    t_trailing_zeros();
    t_dense();
    t_boundary();
    t_backpressure();
    finish_run();
  end
endmodule